// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This block is the last stage of a single-precision arithmetic datapath. An upstream unit supplies a sign, a signed unbiased exponent and a 27-bit extended significand. The significand holds the hidden one at bit 26, the 23 fraction bits at 25..3, and guard, round and sticky bits at 2..0. The block brings an out-of-range exponent back into the denormal range with a sticky right shift and rounds under one of four directed modes. It renormalizes a rounding carry and saturates an exponent that is too large. It then packs a 32-bit word. Inexact, underflow and overflow flags are produced for each operation and are valid in the same cycle as the word.

A flush-to-zero control replaces any input whose exponent is below the normal range with a fixed result chosen by mode and sign. An underflow trap-enable input makes an exact denormal result report underflow too. There is no handshake. A new operation may be presented on every clock, and its result appears one clock later from registered outputs. Exact-zero inputs, NaNs and the arithmetic that feeds the block are not handled here.

Top module: `sp_round_pack`

## Requirements
- R1: While reset is held low at a clock edge, the output word and all three flags are cleared to zero on that edge.
- R2: The result of the inputs present at one rising edge appears on the outputs after that edge and holds until the next edge.
- R3: Mode encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. When bits 2..0 are nonzero, nearest adds 3 plus bit 3 and toward zero adds nothing. Toward +infinity adds 8 for a positive sign only, and toward -infinity adds 8 for a negative sign only. Bits 2..0 are then dropped.
- R4: For an exponent in -126..127 with bits 2..0 clear, the word is the sign, then exponent+127 in bits 30..23, then significand bits 25..3 in bits 22..0, and no flag is raised.
- R5: A rounding carry out of bit 26 shifts the significand right by one and adds one to the exponent.
- R6: Any nonzero value in bits 2..0 at rounding time raises inexact.
- R7: An exponent below -126 with flush-to-zero off shifts the significand right by -126 minus the exponent and ORs every shifted-out one into bit 0. If bits 2..0 are nonzero afterwards while bit 26 is clear, both inexact and underflow are raised. A result whose hidden bit is still clear packs with exponent field 0.
- R8: A shift of 27 or more leaves only a sticky 1 in bit 0.
- R9: At exponent -127, when rounding the unshifted significand would carry out of bit 26, the result is the smallest normal (field 1, fraction 0) with inexact and without underflow.
- R10: With flush-to-zero on and an exponent below -126, underflow and inexact are raised. Nearest and toward-zero give a signed zero. Toward +infinity gives word 0x00000001 for a positive sign and 0x80000000 for a negative sign. Toward -infinity gives 0x00000000 for positive and 0x80000001 for negative. An exponent of -126 or above is not affected.
- R11: A final exponent above 127 raises overflow and inexact. Nearest gives signed infinity (field 0xFF, fraction 0) and toward zero gives signed maximum finite (field 0xFE, fraction all ones). Toward +infinity gives +infinity or -maximum, and toward -infinity gives +maximum or -infinity.
- R12: A result with exponent field 0 raises underflow even when exact, but only if the trap enable is high. The trap enable has no effect on a normal result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_sign | input | 1 | Sign of the value, 1 negative |
| in_exp | input | EXP_W (10) | Signed unbiased exponent |
| in_mant | input | 27 | Extended significand, hidden bit at 26, guard/round/sticky at 2..0 |
| in_rmode | input | 2 | Rounding mode (see R3) |
| in_ftz | input | 1 | Flush inputs below the normal range |
| in_uf_trap | input | 1 | Underflow trap enable (see R12) |
| out_word | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Result differs from the exact value |
| out_underflow | output | 1 | Tiny result raised underflow |
| out_overflow | output | 1 | Exponent exceeded the finite range |

## Verification
Some properties are checked on every cycle. An overflow always comes with inexact and one of the two saturation magnitudes. A flush always yields a zero or smallest-denormal word with both underflow and inexact. An exact in-range input always packs with no flags. A denormal word that is inexact never lacks underflow, and toward-zero never returns infinity. The exact rounding increments need the bench's scenarios to be shown: ties to even and the direction chosen by sign. So do the sticky bit that changes a denormal's rounding, the collapse at shift 27, the tiny-after-rounding boundary at exponent -127 and the effect of the trap enable on exact denormals.

// File: rtl/sprp_pkg.sv
// Shared constants, rounding-mode type and rounding-increment function
// for the single-precision round-and-pack unit.
// Assumes the extended significand layout: hidden bit, fraction, then
// GRS_W extra bits below the fraction.
package sprp_pkg;

    localparam int FRAC_W = 23;
    localparam int GRS_W  = 3;
    localparam int EXPF_W = 8;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int MANT_W = SIG_W + GRS_W;
    localparam int WORD_W = 1 + EXPF_W + FRAC_W;
    localparam int BIAS   = (1 << (EXPF_W - 1)) - 1;
    localparam int EMIN   = 1 - BIAS;
    localparam int EMAX   = BIAS;

    localparam logic [MANT_W:0] INC_ULP     = (MANT_W + 1)'(1 << GRS_W);
    localparam logic [MANT_W:0] INC_HALF_M1 = (MANT_W + 1)'((1 << (GRS_W - 1)) - 1);

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    // Amount to add to an extended significand before the extra bits are dropped.
    // low holds the extra bits plus the last kept bit (for ties to even).
    function automatic logic [MANT_W:0] round_inc(input logic sgn,
                                                  input logic [GRS_W:0] low,
                                                  input rmode_e md);
        logic [MANT_W:0] inc;
        inc = '0;
        if (|low[GRS_W-1:0]) begin
            case (md)
                RM_NEAR: inc = INC_HALF_M1 + {{MANT_W{1'b0}}, low[GRS_W]};
                RM_ZERO: inc = '0;
                RM_UP:   if (!sgn) inc = INC_ULP;
                RM_DOWN: if (sgn)  inc = INC_ULP;
                default: inc = '0;
            endcase
        end
        return inc;
    endfunction

endpackage

// File: rtl/sprp_denorm.sv
// Range fix-up ahead of rounding. An exponent below the normal minimum is
// either flagged for flush, resolved as "not tiny after rounding" at the
// boundary exponent, or shifted right with sticky collection and pinned to
// the minimum exponent. In-range values pass through.
// Assumes a nonzero significand with the hidden bit set and EXP_W >= 10.
module sprp_denorm
    import sprp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    sgn_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [MANT_W-1:0]       mant_i,
    input  rmode_e                  mode_i,
    input  logic                    ftz_i,
    output logic [MANT_W-1:0]       mant_o,
    output logic signed [EXP_W:0]   exp_o,
    output logic                    flush_o,
    output logic                    edge_inx_o
);

    localparam int SH_W = $clog2(MANT_W);
    localparam logic signed [EXP_W:0] EMIN_X = (EXP_W + 1)'(EMIN);
    localparam logic signed [EXP_W:0] EDGE_X = (EXP_W + 1)'(EMIN - 1);
    localparam logic signed [EXP_W:0] SH_LIM = (EXP_W + 1)'(MANT_W);

    logic signed [EXP_W:0] exp_w;
    logic signed [EXP_W:0] shamt;
    logic [SH_W-1:0]       sh;
    logic                  below;
    logic                  edge_carry;
    logic [MANT_W-1:0]     shifted;
    logic                  lost;

    // Sign-extend the exponent and measure how far below the range it sits.
    assign exp_w = {exp_i[EXP_W-1], exp_i};
    assign below = exp_w < EMIN_X;
    assign shamt = EMIN_X - exp_w;
    assign sh    = shamt[SH_W-1:0];

    // Boundary case: rounding the unshifted value would carry out of the top.
    assign edge_carry = (exp_w == EDGE_X) &&
        1'(({1'b0, mant_i} + round_inc(sgn_i, mant_i[GRS_W:0], mode_i)) >> MANT_W);

    // Plain right shift plus the OR of every bit pushed out.
    assign shifted = mant_i >> sh;
    assign lost    = |(mant_i & ~({MANT_W{1'b1}} << sh));

    assign flush_o    = below && ftz_i;
    assign edge_inx_o = below && !ftz_i && edge_carry;

    // Select the significand and exponent handed to the rounding stage.
    always_comb begin
        mant_o = mant_i;
        exp_o  = exp_w;
        if (below) begin
            exp_o = EMIN_X;
            if (edge_carry) begin
                mant_o = {1'b1, {(MANT_W - 1){1'b0}}};
            end else if (shamt >= SH_LIM) begin
                mant_o = {{(MANT_W - 1){1'b0}}, 1'b1};
            end else begin
                mant_o = shifted | {{(MANT_W - 1){1'b0}}, lost};
            end
        end
    end

endmodule

// File: rtl/sprp_round.sv
// Rounding stage: applies the mode-dependent increment when extra bits are
// nonzero, renormalizes a carry out of the hidden-bit position and drops the
// extra bits. Reports inexact and tiny-before-rounding.
// Assumes the significand has no bits set above the hidden-bit position.
module sprp_round
    import sprp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                  sgn_i,
    input  logic signed [EXP_W:0] exp_i,
    input  logic [MANT_W-1:0]     mant_i,
    input  rmode_e                mode_i,
    output logic [SIG_W-1:0]      sig_o,
    output logic signed [EXP_W:0] exp_o,
    output logic                  inexact_o,
    output logic                  tiny_o
);

    logic [MANT_W:0] inc;
    logic            carry;

    // Increment chosen from mode, sign and the low bits.
    assign inc = round_inc(sgn_i, mant_i[GRS_W:0], mode_i);

    // Inexact and tiny are judged on the value before rounding.
    assign inexact_o = |mant_i[GRS_W-1:0];
    assign tiny_o    = inexact_o && !mant_i[MANT_W-1];

    // Carry out of the top after adding the increment.
    assign carry = 1'(({1'b0, mant_i} + inc) >> MANT_W);

    // Drop the extra bits, one more position when the sum carried.
    assign sig_o = carry ? SIG_W'(({1'b0, mant_i} + inc) >> (GRS_W + 1))
                         : SIG_W'(({1'b0, mant_i} + inc) >> GRS_W);
    assign exp_o = carry ? exp_i + (EXP_W + 1)'(1) : exp_i;

endmodule

// File: rtl/sprp_pack.sv
// Packing stage: saturates an exponent above the finite range according to
// mode and sign, packs a denormal with a zero exponent field, or packs a
// normal with a biased exponent and the hidden bit removed.
// Assumes a rounded significand and an exponent no lower than the minimum.
module sprp_pack
    import sprp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                  sgn_i,
    input  logic signed [EXP_W:0] exp_i,
    input  logic [SIG_W-1:0]      sig_i,
    input  rmode_e                mode_i,
    input  logic                  uf_trap_i,
    output logic [WORD_W-1:0]     word_o,
    output logic                  ovf_o,
    output logic                  uf_trap_o
);

    localparam logic signed [EXP_W:0] EMAX_X = (EXP_W + 1)'(EMAX);
    localparam logic signed [EXP_W:0] BIAS_X = (EXP_W + 1)'(BIAS);
    localparam logic [WORD_W-2:0] INF_MAG = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAX_MAG = {{(EXPF_W - 1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    logic to_inf;

    // Overflow goes to infinity when the mode rounds away from zero for this sign.
    assign ovf_o  = exp_i > EMAX_X;
    assign to_inf = (mode_i == RM_NEAR) ||
                    (mode_i == RM_UP && !sgn_i) ||
                    (mode_i == RM_DOWN && sgn_i);

    // Build the output word for the saturated, denormal or normal case.
    always_comb begin
        uf_trap_o = 1'b0;
        if (ovf_o) begin
            word_o = {sgn_i, to_inf ? INF_MAG : MAX_MAG};
        end else if (!sig_i[SIG_W-1]) begin
            word_o    = {sgn_i, {EXPF_W{1'b0}}, sig_i[FRAC_W-1:0]};
            uf_trap_o = uf_trap_i;
        end else begin
            word_o = {sgn_i, EXPF_W'(exp_i + BIAS_X), sig_i[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/sp_round_pack.sv
// Single-precision round-and-pack unit. Chains range fix-up, rounding and
// packing, overrides the result on a flush, merges the flags and registers
// word and flags together for a one-cycle latency.
// Assumes a nonzero input significand with the hidden bit set and nothing
// above it; no handshake, one operation per clock.
module sp_round_pack
    import sprp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic [1:0]              in_rmode,
    input  logic                    in_ftz,
    input  logic                    in_uf_trap,
    output logic [WORD_W-1:0]       out_word,
    output logic                    out_inexact,
    output logic                    out_underflow,
    output logic                    out_overflow
);

    localparam logic signed [EXP_W:0] EMIN_X = (EXP_W + 1)'(EMIN);
    localparam logic signed [EXP_W:0] EMAX_X = (EXP_W + 1)'(EMAX);
    localparam logic signed [EXP_W:0] BIAS_X = (EXP_W + 1)'(BIAS);
    localparam logic [WORD_W-2:0] INF_MAG = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAX_MAG = {{(EXPF_W - 1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    rmode_e                md;
    logic [MANT_W-1:0]     dn_mant;
    logic signed [EXP_W:0] dn_exp;
    logic                  dn_flush;
    logic                  dn_edge_inx;
    logic [SIG_W-1:0]      rd_sig;
    logic signed [EXP_W:0] rd_exp;
    logic                  rd_inexact;
    logic                  rd_tiny;
    logic [WORD_W-1:0]     pk_word;
    logic                  pk_ovf;
    logic                  pk_uf;
    logic                  flush_min;
    logic [WORD_W-1:0]     nxt_word;
    logic                  nxt_inexact;
    logic                  nxt_underflow;
    logic                  nxt_overflow;
    logic                  live_q;

    assign md = rmode_e'(in_rmode);

    sprp_denorm #(.EXP_W(EXP_W)) u_denorm (
        .sgn_i      (in_sign),
        .exp_i      (in_exp),
        .mant_i     (in_mant),
        .mode_i     (md),
        .ftz_i      (in_ftz),
        .mant_o     (dn_mant),
        .exp_o      (dn_exp),
        .flush_o    (dn_flush),
        .edge_inx_o (dn_edge_inx)
    );

    sprp_round #(.EXP_W(EXP_W)) u_round (
        .sgn_i     (in_sign),
        .exp_i     (dn_exp),
        .mant_i    (dn_mant),
        .mode_i    (md),
        .sig_o     (rd_sig),
        .exp_o     (rd_exp),
        .inexact_o (rd_inexact),
        .tiny_o    (rd_tiny)
    );

    sprp_pack #(.EXP_W(EXP_W)) u_pack (
        .sgn_i     (in_sign),
        .exp_i     (rd_exp),
        .sig_i     (rd_sig),
        .mode_i    (md),
        .uf_trap_i (in_uf_trap),
        .word_o    (pk_word),
        .ovf_o     (pk_ovf),
        .uf_trap_o (pk_uf)
    );

    // A flush returns the smallest denormal when the mode rounds away for this sign.
    assign flush_min = (md == RM_UP && !in_sign) || (md == RM_DOWN && in_sign);

    // Merge flush override and per-stage flags into the next registered result.
    always_comb begin
        if (dn_flush) begin
            nxt_word      = {in_sign, {(WORD_W - 2){1'b0}}, flush_min};
            nxt_inexact   = 1'b1;
            nxt_underflow = 1'b1;
            nxt_overflow  = 1'b0;
        end else begin
            nxt_word      = pk_word;
            nxt_inexact   = dn_edge_inx || rd_inexact || pk_ovf;
            nxt_underflow = rd_tiny || pk_uf;
            nxt_overflow  = pk_ovf;
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word      <= '0;
            out_inexact   <= 1'b0;
            out_underflow <= 1'b0;
            out_overflow  <= 1'b0;
        end else begin
            out_word      <= nxt_word;
            out_inexact   <= nxt_inexact;
            out_underflow <= nxt_underflow;
            out_overflow  <= nxt_overflow;
        end
    end

    // Marks that the previous edge captured real inputs rather than reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    logic signed [EXP_W:0] in_exp_w;
    logic [EXPF_W-1:0]     in_bexp;
    assign in_exp_w = {in_exp[EXP_W-1], in_exp};
    assign in_bexp  = EXPF_W'(in_exp_w + BIAS_X);

    // R1: the first result after reset is still the cleared state
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> (out_word == '0 && !out_inexact && !out_underflow && !out_overflow));

    // R11: overflow carries inexact and one of the two saturation magnitudes
    a_r11_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && out_overflow |->
            out_inexact && (out_word[WORD_W-2:0] == INF_MAG || out_word[WORD_W-2:0] == MAX_MAG));

    // R10: a flushed input yields zero or smallest denormal with both flags
    a_r10_ftz_flush: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(in_ftz && (in_exp_w < EMIN_X)) |->
            out_underflow && out_inexact && !out_overflow && out_word[WORD_W-2:1] == '0);

    // R4: an exact in-range input packs directly with no flags
    a_r4_exact_normal: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(in_exp_w >= EMIN_X && in_exp_w <= EMAX_X && in_mant[GRS_W-1:0] == '0) |->
            !out_inexact && !out_underflow && !out_overflow &&
            out_word[WORD_W-1] == $past(in_sign) &&
            out_word[WORD_W-2:FRAC_W] == $past(in_bexp) &&
            out_word[FRAC_W-1:0] == $past(in_mant[MANT_W-2:GRS_W]));

    // R7: an inexact result with a zero exponent field always reports underflow
    a_r7_tiny_inexact_uf: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && out_inexact && out_word[WORD_W-2:FRAC_W] == '0 |-> out_underflow);

    // R3: toward-zero rounding never produces infinity
    a_r3_rz_never_inf: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(in_rmode) == RM_ZERO |-> out_word[WORD_W-2:0] != INF_MAG);

endmodule

// File: tb/sp_round_pack_tb.sv
module sp_round_pack_tb;

    localparam int EXP_W = 10;
    localparam time TCLK = 8ns;

    typedef struct packed {
        logic              s;
        logic [EXP_W-1:0]  e;
        logic [26:0]       m;
        logic [1:0]        md;
        logic              ftz;
        logic              trap;
        logic [31:0]       res;
        logic              inx;
        logic              uf;
        logic              ovf;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 40;
    // Fields: sign, exp, mant, mode, ftz, trap, word, inexact, underflow, overflow, requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'sd0,    27'h4000000, 2'd0, 1'b0, 1'b0, 32'h3F800000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b1, 10'sd0,    27'h6000000, 2'd0, 1'b0, 1'b0, 32'hBFC00000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 10'sd127,  27'h7FFFFF8, 2'd1, 1'b0, 1'b0, 32'h7F7FFFFF, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, -10'sd126, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00800000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 10'sd0,    27'h4000004, 2'd0, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 tie even down
        '{1'b0, 10'sd0,    27'h400000C, 2'd0, 1'b0, 1'b0, 32'h3F800002, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 tie odd up
        '{1'b0, 10'sd0,    27'h4000005, 2'd0, 1'b0, 1'b0, 32'h3F800001, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 above half
        '{1'b0, 10'sd0,    27'h4000001, 2'd1, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
        '{1'b0, 10'sd0,    27'h4000001, 2'd2, 1'b0, 1'b0, 32'h3F800001, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 10'sd0,    27'h4000001, 2'd2, 1'b0, 1'b0, 32'hBF800000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 10'sd0,    27'h4000001, 2'd3, 1'b0, 1'b0, 32'hBF800001, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 10'sd0,    27'h4000001, 2'd3, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 10'sd0,    27'h7FFFFFC, 2'd0, 1'b0, 1'b0, 32'h40000000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        '{1'b0, -10'sd126, 27'h7FFFFFC, 2'd0, 1'b0, 1'b0, 32'h01000000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        '{1'b0, 10'sd127,  27'h7FFFFFC, 2'd0, 1'b0, 1'b0, 32'h7F800000, 1'b1, 1'b0, 1'b1, 4'd11}, // R11 via carry
        '{1'b0, 10'sd128,  27'h4000000, 2'd1, 1'b0, 1'b0, 32'h7F7FFFFF, 1'b1, 1'b0, 1'b1, 4'd11}, // R11
        '{1'b1, 10'sd128,  27'h4000000, 2'd2, 1'b0, 1'b0, 32'hFF7FFFFF, 1'b1, 1'b0, 1'b1, 4'd11}, // R11
        '{1'b1, 10'sd128,  27'h4000000, 2'd3, 1'b0, 1'b0, 32'hFF800000, 1'b1, 1'b0, 1'b1, 4'd11}, // R11
        '{1'b0, 10'sd128,  27'h4000000, 2'd2, 1'b0, 1'b0, 32'h7F800000, 1'b1, 1'b0, 1'b1, 4'd11}, // R11
        '{1'b0, 10'sd128,  27'h4000000, 2'd3, 1'b0, 1'b0, 32'h7F7FFFFF, 1'b1, 1'b0, 1'b1, 4'd11}, // R11
        '{1'b1, 10'sd128,  27'h4000000, 2'd0, 1'b0, 1'b0, 32'hFF800000, 1'b1, 1'b0, 1'b1, 4'd11}, // R11
        '{1'b0, -10'sd127, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00400000, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 trap off
        '{1'b0, -10'sd127, 27'h4000000, 2'd0, 1'b0, 1'b1, 32'h00400000, 1'b0, 1'b1, 1'b0, 4'd12}, // R12 trap on
        '{1'b0, -10'sd127, 27'h4000001, 2'd0, 1'b0, 1'b0, 32'h00400000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7
        '{1'b0, -10'sd130, 27'h4000008, 2'd2, 1'b0, 1'b0, 32'h00080001, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 sticky
        '{1'b0, -10'sd127, 27'h7FFFFF8, 2'd0, 1'b0, 1'b0, 32'h00800000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 rounds to normal
        '{1'b0, -10'sd200, 27'h4000000, 2'd2, 1'b0, 1'b0, 32'h00000001, 1'b1, 1'b1, 1'b0, 4'd8},  // R8
        '{1'b0, -10'sd200, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd8},  // R8
        '{1'b1, -10'sd153, 27'h4000000, 2'd3, 1'b0, 1'b0, 32'h80000001, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 shift 27
        '{1'b0, -10'sd150, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 shift 24
        '{1'b0, -10'sd127, 27'h7FFFFFC, 2'd0, 1'b0, 1'b0, 32'h00800000, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 not tiny
        '{1'b0, -10'sd127, 27'h7FFFFFC, 2'd1, 1'b0, 1'b0, 32'h007FFFFF, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 stays tiny
        '{1'b0, -10'sd127, 27'h4000000, 2'd0, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b0, -10'sd127, 27'h4000000, 2'd2, 1'b1, 1'b0, 32'h00000001, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b1, -10'sd127, 27'h4000000, 2'd2, 1'b1, 1'b0, 32'h80000000, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b1, -10'sd127, 27'h4000000, 2'd3, 1'b1, 1'b0, 32'h80000001, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b0, -10'sd127, 27'h4000000, 2'd3, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b1, -10'sd300, 27'h4000000, 2'd1, 1'b1, 1'b0, 32'h80000000, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b0, -10'sd126, 27'h4000000, 2'd0, 1'b1, 1'b0, 32'h00800000, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 not below
        '{1'b0, -10'sd126, 27'h4000000, 2'd0, 1'b0, 1'b1, 32'h00800000, 1'b0, 1'b0, 1'b0, 4'd12}  // R12 normal
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_sign = 1'b0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [26:0]             in_mant = '0;
    logic [1:0]              in_rmode = '0;
    logic                    in_ftz = 1'b0;
    logic                    in_uf_trap = 1'b0;
    logic [31:0]             out_word;
    logic                    out_inexact;
    logic                    out_underflow;
    logic                    out_overflow;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(TCLK / 2) clk = ~clk;

    sp_round_pack #(.EXP_W(EXP_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_sign       (in_sign),
        .in_exp        (in_exp),
        .in_mant       (in_mant),
        .in_rmode      (in_rmode),
        .in_ftz        (in_ftz),
        .in_uf_trap    (in_uf_trap),
        .out_word      (out_word),
        .out_inexact   (out_inexact),
        .out_underflow (out_underflow),
        .out_overflow  (out_overflow)
    );

    task automatic chk(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_sign    = v.s;
        in_exp     = v.e;
        in_mant    = v.m;
        in_rmode   = v.md;
        in_ftz     = v.ftz;
        in_uf_trap = v.trap;
    endtask

    task automatic chk_all(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("vec%0d", idx);
        chk(int'(v.req), {tag, " word"},      out_word,              v.res);
        chk(int'(v.req), {tag, " inexact"},   {31'b0, out_inexact},  {31'b0, v.inx});
        chk(int'(v.req), {tag, " underflow"}, {31'b0, out_underflow}, {31'b0, v.uf});
        chk(int'(v.req), {tag, " overflow"},  {31'b0, out_overflow}, {31'b0, v.ovf});
    endtask

    initial begin
        #(TCLK * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset held with an overflowing input present
        drive(VECS[14]);
        repeat (3) @(negedge clk);
        chk(1, "reset word", out_word, 32'h0);
        chk(1, "reset flags", {29'b0, out_inexact, out_underflow, out_overflow}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            // R2: new inputs do not reach the outputs before the next edge
            if (i > 0) chk(2, $sformatf("hold before edge vec%0d", i), out_word, VECS[i-1].res);
            @(negedge clk);
            chk_all(VECS[i], i);
        end

        // R2: back-to-back operations each appear exactly one edge later
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        drive(VECS[16]);
        chk(2, "back-to-back first", out_word, 32'h3F800000);
        @(negedge clk);
        chk(2, "back-to-back second", out_word, 32'hFF7FFFFF);

        // R1: reset in mid-run clears a live overflow result
        drive(VECS[20]);
        @(negedge clk);
        chk(11, "pre-reset word", out_word, 32'hFF800000);
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, "mid-run reset word", out_word, 32'h0);
        chk(1, "mid-run reset flags", {29'b0, out_inexact, out_underflow, out_overflow}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "after reset release", out_word, 32'hFF800000);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule